// File: doc/BRIEF.md
# Dual-Field Multiply-Accumulate Unit

This block is a multiply-accumulate engine for multi-word public-key arithmetic. It works on 32-bit unsigned words in one of two fields, chosen per command. In integer mode, partial sums ripple carries as in ordinary binary addition. In polynomial mode, every addition is a carry-free XOR, which gives products of binary polynomials over GF(2). Both modes share one 32x16 multiplier array. That array is made of adder cells that switch into XOR-only behaviour when the field select is low. The same kind of cell builds the 72-bit accumulator adder.

A host hands over commands on a valid/ready channel and may carry on with other work while the unit runs. A full 32x32 product takes two passes through the array. The first pass uses the low 16 bits of the second operand. The second pass uses the high 16 bits, weighted by 2^16. Reads of the accumulator come back on a separate valid/ready response channel. A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low while the unit is busy or while a response waits to be taken. A response stays valid, with its data unchanged, until the edge where `rsp_ready` is high.

Top module: `dfmac_unit`

## Requirements
- R1: After reset the accumulator is zero, `busy`, `done` and `rsp_valid` are low, and `cmd_ready` is high.
- R2: Op code 0 (multiply) with `cmd_mode`=1 (integer) replaces the accumulator with the unsigned 64-bit product of `cmd_a` and `cmd_b`, and the 8 guard bits become zero.
- R3: Op code 0 with `cmd_mode`=0 (polynomial) replaces the accumulator with the carry-less product of the two operands, taken as binary polynomials.
- R4: Op code 1 (accumulate) in integer mode adds the 64-bit product to the 72-bit accumulator modulo 2^72, so carries beyond bit 63 land in the guard bits.
- R5: Op code 1 in polynomial mode XORs the carry-less product into the accumulator, and the guard bits (71..64) stay zero when they were zero before.
- R6: After a multiply or accumulate is accepted, `busy` is high for exactly two cycles, then `done` is high for one cycle with `busy` low and the final accumulator in place.
- R7: Op code 2 (clear) zeroes the accumulator, and `done` is high in the cycle after acceptance.
- R8: Op code 3 (shift) moves the accumulator right by 32 with zero fill in either mode, and `done` is high in the cycle after acceptance.
- R9: Op code 4 returns accumulator bits 31..0, zero-extended, on `rsp_data`. Op code 5 returns bits 71..32. Each response is valid in the cycle after acceptance.
- R10: While `busy` or `rsp_valid` is high, `cmd_ready` is low. A read issued during a multiply is held off until the product is complete. A pending response keeps `rsp_valid` high and `rsp_data` stable until `rsp_ready`.
- R11: Op codes 6 and 7 are accepted but leave the accumulator unchanged, raise no `done` and produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit can take a command |
| cmd_op | input | 3 | Operation code (see R2..R11) |
| cmd_mode | input | 1 | Field select: 1 integer, 0 polynomial |
| cmd_a | input | 32 | Multiplicand word |
| cmd_b | input | 32 | Multiplier word |
| busy | output | 1 | Multiply passes in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 40 | Read data, zero-extended |

## Verification
The assertions assume that reset is applied before the first command, and that `cmd_op` may carry any of the eight codes. They also assume that `rsp_ready` may be held low for any number of cycles. The polynomial guard-bit property holds only when the guard bits start at zero. The bench respects this by clearing the accumulator before every polynomial chain. The bench drives inputs only at falling edges and holds `cmd_valid` until it sees `cmd_ready` high. It also stalls the response channel on purpose, to exercise the hold rule.

// File: rtl/dfmac_pkg.sv
package dfmac_pkg;
  typedef enum logic [2:0] {
    OP_MUL  = 3'd0,
    OP_MAC  = 3'd1,
    OP_CLR  = 3'd2,
    OP_SHR  = 3'd3,
    OP_RDLO = 3'd4,
    OP_RDHI = 3'd5
  } mac_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } mac_st_e;

  localparam logic MODE_POLY = 1'b0;
  localparam logic MODE_INT  = 1'b1;
endpackage

// File: rtl/df_fa.sv
// Dual-field full adder: fsel=1 gives a normal full adder, fsel=0 a plain XOR
// with the carry output held at zero.
module df_fa (
  input  logic x,
  input  logic y,
  input  logic cin,
  input  logic fsel,
  output logic s,
  output logic cout
);
  assign s    = x ^ y ^ cin;
  assign cout = fsel & ((x & y) | (cin & (x ^ y)));
endmodule

// File: rtl/dfa_add.sv
// W-bit ripple adder built from dual-field cells; the top bit drops its carry.
module dfa_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         fsel,
  output logic [W-1:0] s
);
  logic [W-1:0] c;
  assign c[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i < W - 1) begin : g_cell
      df_fa u_cell (
        .x   (a[i]),
        .y   (b[i]),
        .cin (c[i]),
        .fsel(fsel),
        .s   (s[i]),
        .cout(c[i+1])
      );
    end else begin : g_top
      assign s[i] = a[i] ^ b[i] ^ c[i];
    end
  end
endmodule

// File: rtl/umul_array.sv
// AW x BW unified multiplier: one dual-field adder row per multiplier bit.
module umul_array #(
  parameter int AW = 32,
  parameter int BW = 16
) (
  input  logic [AW-1:0]    a,
  input  logic [BW-1:0]    b,
  input  logic             fsel,
  output logic [AW+BW-1:0] p
);
  localparam int PW = AW + BW;

  logic [PW-1:0] part [BW+1];
  logic [PW-1:0] pp   [BW];

  assign part[0] = '0;

  for (genvar i = 0; i < BW; i++) begin : g_row
    assign pp[i] = {{BW{1'b0}}, (a & {AW{b[i]}})} << i;
    dfa_add #(.W(PW)) u_row (
      .a   (part[i]),
      .b   (pp[i]),
      .fsel(fsel),
      .s   (part[i+1])
    );
  end

  assign p = part[BW];
endmodule

// File: rtl/dfmac_unit.sv
module dfmac_unit
  import dfmac_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ACC_W  = 72,
  parameter int RD_W   = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic              cmd_mode,
  input  logic [WORD_W-1:0] cmd_a,
  input  logic [WORD_W-1:0] cmd_b,
  output logic              busy,
  output logic              done,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [RD_W-1:0]   rsp_data
);
  localparam int HALF_W  = WORD_W / 2;
  localparam int PROD_W  = WORD_W + HALF_W;
  localparam int GUARD_W = ACC_W - 2 * WORD_W;

  mac_st_e           st;
  mac_op_e           op_q;
  logic              fsel_q;
  logic [WORD_W-1:0] a_q, b_q;
  logic [ACC_W-1:0]  acc_q;
  logic              done_q, rsp_valid_q;
  logic [RD_W-1:0]   rsp_data_q;

  logic              accept;
  logic [HALF_W-1:0] mult_b;
  logic [PROD_W-1:0] prod;
  logic [ACC_W-1:0]  prod_ext, addend, base, acc_sum;
  logic [RD_W-1:0]   lo_ext, hi_ext;

  assign busy      = (st != ST_IDLE);
  assign cmd_ready = (st == ST_IDLE) && !rsp_valid_q;
  assign accept    = cmd_valid && cmd_ready;
  assign done      = done_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

  // Pass select: low half of the multiplier first, then the high half.
  assign mult_b = (st == ST_HIGH) ? b_q[WORD_W-1:HALF_W] : b_q[HALF_W-1:0];

  umul_array #(.AW(WORD_W), .BW(HALF_W)) u_mul (
    .a   (a_q),
    .b   (mult_b),
    .fsel(fsel_q),
    .p   (prod)
  );

  assign prod_ext = ACC_W'(prod);
  assign addend   = (st == ST_HIGH) ? (prod_ext << HALF_W) : prod_ext;
  assign base     = (st == ST_LOW && op_q == OP_MUL) ? '0 : acc_q;

  dfa_add #(.W(ACC_W)) u_acc_add (
    .a   (base),
    .b   (addend),
    .fsel(fsel_q),
    .s   (acc_sum)
  );

  assign lo_ext = RD_W'(acc_q[WORD_W-1:0]);
  assign hi_ext = RD_W'(acc_q >> WORD_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      op_q        <= OP_MUL;
      fsel_q      <= MODE_INT;
      a_q         <= '0;
      b_q         <= '0;
      acc_q       <= '0;
      done_q      <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (rsp_valid_q && rsp_ready) rsp_valid_q <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            case (cmd_op)
              OP_MUL, OP_MAC: begin
                op_q   <= mac_op_e'(cmd_op);
                fsel_q <= cmd_mode;
                a_q    <= cmd_a;
                b_q    <= cmd_b;
                st     <= ST_LOW;
              end
              OP_CLR: begin
                acc_q  <= '0;
                done_q <= 1'b1;
              end
              OP_SHR: begin
                acc_q  <= acc_q >> WORD_W;
                done_q <= 1'b1;
              end
              OP_RDLO: begin
                rsp_valid_q <= 1'b1;
                rsp_data_q  <= lo_ext;
              end
              OP_RDHI: begin
                rsp_valid_q <= 1'b1;
                rsp_data_q  <= hi_ext;
              end
              default: ;
            endcase
          end
        end
        ST_LOW: begin
          acc_q <= acc_sum;
          st    <= ST_HIGH;
        end
        ST_HIGH: begin
          acc_q  <= acc_sum;
          st     <= ST_IDLE;
          done_q <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy ##1 !busy);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || rsp_valid) |-> !cmd_ready);

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R5
  poly_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fsel_q == MODE_POLY && acc_q[ACC_W-1 -: GUARD_W] == '0)
      |=> acc_q[ACC_W-1 -: GUARD_W] == '0);

  // R11
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_op > 3'd5) |=> (!done && !rsp_valid && !busy && $stable(acc_q)));
endmodule

// File: tb/test_dfmac_unit.sv
module test_dfmac_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = 3'd0;
  logic        cmd_mode = 1'b1;
  logic [31:0] cmd_a = '0, cmd_b = '0;
  logic        busy, done, rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [39:0] rsp_data;

  int checks = 0;
  int errors = 0;
  logic [71:0] model = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dfmac_unit i_dfmac_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_mode(cmd_mode), .cmd_a(cmd_a), .cmd_b(cmd_b),
    .busy(busy), .done(done), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data)
  );

  task automatic chk(input logic ok, input string req, input logic [71:0] act,
                     input logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] clmul(input logic [31:0] a, input logic [31:0] b);
    logic [63:0] r = '0;
    for (int i = 0; i < 32; i++) if (b[i]) r ^= (64'(a) << i);
    return r;
  endfunction

  task automatic issue(input logic [2:0] op, input logic mode,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    cmd_op = op; cmd_mode = mode; cmd_a = a; cmd_b = b; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // Multiply or accumulate with timing checks and model update (R2..R6).
  task automatic mulop(input logic mac, input logic mode,
                       input logic [31:0] a, input logic [31:0] b, input string req);
    logic [71:0] p;
    issue(mac ? 3'd1 : 3'd0, mode, a, b);
    chk(busy === 1'b1 && done === 1'b0, "R6 busy cycle 1", 72'(busy), 72'd1);
    @(negedge clk);
    chk(busy === 1'b1 && done === 1'b0, "R6 busy cycle 2", 72'(busy), 72'd1);
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b1, "R6 done pulse", 72'({busy, done}), 72'b01);
    p = mode ? 72'(64'(a) * 64'(b)) : 72'(clmul(a, b));
    if (!mac) model = p;
    else if (mode) model = model + p;
    else model = model ^ p;
    @(negedge clk);
    chk(done === 1'b0, "R6 done one cycle", 72'(done), 72'd0);
  endtask

  task automatic rd(input logic hi, output logic [39:0] d);
    issue(hi ? 3'd5 : 3'd4, 1'b1, '0, '0);
    chk(rsp_valid === 1'b1, "R9 response valid", 72'(rsp_valid), 72'd1);
    d = rsp_data;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic check_acc(input string req);
    logic [39:0] lo, hi;
    rd(1'b0, lo);
    rd(1'b1, hi);
    chk({hi, lo[31:0]} === model, req, {hi, lo[31:0]}, model);
  endtask

  task automatic simple(input logic [2:0] op, input string req);
    issue(op, 1'b1, '0, '0);
    chk(done === 1'b1, req, 72'(done), 72'd1);
    if (op == 3'd2) model = '0;
    else model = model >> 32;
  endtask

  task automatic t_reset();
    chk(cmd_ready === 1'b1 && busy === 1'b0 && done === 1'b0 && rsp_valid === 1'b0,
        "R1 reset outputs", 72'({cmd_ready, busy, done, rsp_valid}), 72'b1000);
    model = '0;
    check_acc("R1 accumulator zero");
  endtask

  task automatic t_int_mul();
    mulop(0, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2"); check_acc("R2 max x max");
    mulop(0, 1, 32'h0001_0000, 32'h0000_FFFF, "R2"); check_acc("R2 half boundary");
    mulop(0, 1, 32'h1234_5678, 32'h9ABC_DEF0, "R2"); check_acc("R2 mixed");
    mulop(0, 1, 32'd0, 32'hDEAD_BEEF, "R2");         check_acc("R2 zero operand");
  endtask

  task automatic t_poly_mul();
    mulop(0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3"); check_acc("R3 all ones");
    mulop(0, 0, 32'h8000_0001, 32'h8000_0000, "R3"); check_acc("R3 top bits");
    mulop(0, 0, 32'h1234_5678, 32'h9ABC_DEF0, "R3"); check_acc("R3 mixed");
  endtask

  task automatic t_int_mac();
    simple(3'd2, "R7 clear done");
    for (int i = 0; i < 40; i++) mulop(1, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4");
    check_acc("R4 saturated chain beyond 64 bits");
    for (int i = 0; i < 60; i++) mulop(1, 1, $urandom, $urandom, "R4");
    check_acc("R4 random chain");
    for (int i = 0; i < 230; i++) mulop(1, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4");
    check_acc("R4 wrap modulo 2^72");
  endtask

  task automatic t_poly_mac();
    simple(3'd2, "R7 clear done");
    check_acc("R7 cleared");
    for (int i = 0; i < 50; i++) mulop(1, 0, $urandom, $urandom, "R5");
    check_acc("R5 xor chain");
    chk(model[71:64] === 8'd0, "R5 guard zero", 72'(model[71:64]), 72'd0);
    for (int i = 0; i < 20; i++) mulop(1, 0, 32'hFFFF_FFFF, $urandom, "R5");
    check_acc("R5 xor chain dense");
  endtask

  task automatic t_shift();
    mulop(0, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R8");
    for (int i = 0; i < 3; i++) mulop(1, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R8");
    simple(3'd3, "R8 shift done");
    check_acc("R8 shift by 32 carries guard bits down");
    simple(3'd3, "R8 shift done");
    check_acc("R8 second shift");
    mulop(0, 0, 32'hF0F0_F0F0, 32'h0F0F_0F0F, "R8");
    simple(3'd3, "R8 shift done poly");
    check_acc("R8 shift poly");
  endtask

  task automatic t_backpressure();
    logic [39:0] d0;
    mulop(0, 1, 32'hCAFE_F00D, 32'h1357_9BDF, "R10");
    issue(3'd4, 1'b1, '0, '0);
    d0 = rsp_data;
    for (int i = 0; i < 3; i++) begin
      chk(rsp_valid === 1'b1 && rsp_data === d0 && cmd_ready === 1'b0,
          "R10 response held", 72'(rsp_data), 72'(d0));
      @(negedge clk);
    end
    chk(d0 === 40'(model[31:0]), "R9 low word", 72'(d0), 72'(model[31:0]));
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(rsp_valid === 1'b0 && cmd_ready === 1'b1, "R10 response released",
        72'({rsp_valid, cmd_ready}), 72'b01);
  endtask

  task automatic t_read_stall();
    logic [39:0] d;
    model = 72'(64'(32'h8765_4321) * 64'(32'hFEDC_BA98));
    issue(3'd0, 1'b1, 32'h8765_4321, 32'hFEDC_BA98);
    chk(cmd_ready === 1'b0, "R10 ready low while busy", 72'(cmd_ready), 72'd0);
    rd(1'b0, d);
    chk(d === 40'(model[31:0]), "R10 read waits for product", 72'(d), 72'(model[31:0]));
    rd(1'b1, d);
    chk(d === model[71:32], "R9 high part", 72'(d), 72'(model[71:32]));
  endtask

  task automatic t_bad_op();
    mulop(0, 1, 32'h0BAD_C0DE, 32'h7777_1111, "R11");
    for (int op = 6; op < 8; op++) begin
      issue(3'(op), 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      chk(done === 1'b0 && rsp_valid === 1'b0 && busy === 1'b0,
          "R11 no activity", 72'({done, rsp_valid, busy}), 72'd0);
    end
    check_acc("R11 accumulator unchanged");
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_int_mul();
    t_poly_mul();
    t_int_mac();
    t_poly_mac();
    t_shift();
    t_backpressure();
    t_read_stall();
    t_bad_op();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule